// File: doc/BRIEF.md
# Dual-Mode Bunch Veto Line Encoder

This block drives the single veto wire that runs from the clock-and-control crate to the detector front ends. The decision about which bunch to reject is made upstream. The block receives a veto request together with the bunch number and puts it on the wire in one of two encodings, all on the fast synchronous clock. The fast clock runs at an exact integer multiple of the bunch clock, for example 20 × 5 MHz or 22 × 4.5 MHz.

In serial mode the wire idles low. Each rejected bunch is sent as a frame: one high start bit, then the bunch number MSB first, one bit per fast clock. A train holds about 3000 bunches, so 12 bits are enough. Requests that arrive while a frame is on the wire wait in a small FIFO. If the FIFO overflows, the excess request is dropped and a sticky flag records the loss. In level mode, which is kept for older front ends, the wire is high or low for a whole bunch period. It changes only on the bunch-period tick.

The mode is set while the run is configured. It is taken from the select input only while no train is active. A change of mode flushes any queued or partly sent work.

Top module: `veto_line_encoder`

## Requirements
- R1: After reset `veto_o` and `overflow_o` are low and the mode is serial (mode value 0).
- R2: In serial mode (`mode_sel_i` = 0) the wire idles low. A request sampled at clock edge k, with the FIFO empty and no frame in flight, puts the start bit (1) on `veto_o` after edge k+1. The 12 bunch-number bits follow MSB first, one per clock, after edges k+2 to k+13.
- R3: Queued requests are sent in arrival order. The next start bit follows the last data bit of the previous frame with no idle cycle between them.
- R4: Up to FIFO_DEPTH (4) requests wait behind the frame in flight. A request that arrives at a full FIFO in the same cycle that a frame is dequeued is accepted.
- R5: A serial request that arrives at a full FIFO with no dequeue in that cycle is dropped and sets `overflow_o`. The flag stays high until reset, including across mode changes.
- R6: In level mode (`mode_sel_i` = 1) `veto_o` changes only on edges where `bunch_tick_i` is high. It becomes 1 if a request was seen since the previous tick, counting a request in the tick cycle itself, and 0 otherwise.
- R7: `mode_sel_i` is ignored while `train_active_i` is high. The active mode stays as it was.
- R8: A mode change drives `veto_o` low on the next cycle and discards queued requests, any frame in flight and any pending level. Requests in the switching cycle are dropped. Requests in level mode are never queued for serial frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast synchronous clock (~100 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Requested mode: 0 serial, 1 level |
| train_active_i | input | 1 | High while a bunch train is running |
| bunch_tick_i | input | 1 | One-cycle pulse at each bunch-period boundary |
| veto_req_i | input | 1 | Veto request for `veto_bunch_i` |
| veto_bunch_i | input | BUNCH_W | Number of the bunch to reject |
| veto_o | output | 1 | Veto line to the front ends |
| overflow_o | output | 1 | Sticky: a serial request was lost |

## Verification
Two collisions matter most. The first is a new request reaching a full FIFO in exactly the cycle that a finished frame dequeues the head entry. The bench fills the FIFO with five back-to-back requests, then times one more to land on the dequeue edge. The request must be accepted with no overflow. The second is a mode change that lands while a frame is half sent. The line must drop low on the next cycle, and the remaining bits must never appear. A queue-based reference model, stepped every clock, judges the line and the flag in each cycle.

// File: rtl/veto_enc_pkg.sv
package veto_enc_pkg;

    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_LEVEL  = 1'b1
    } veto_mode_e;

endpackage

// File: rtl/veto_req_fifo.sv
module veto_req_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         avail_o,
    output logic         ovf_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        do_pop, do_push, room;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && (st_q.cnt != '0);
        room    = (st_q.cnt < CW'(DEPTH)) || do_pop;
        do_push = push_i && room;
        if (flush_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_pop) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            if (do_push) begin
                st_d.mem[st_q.wr] = data_i;
                st_d.wr           = ptr_next(st_q.wr);
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
            if (push_i && !room) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign avail_o = (st_q.cnt != '0);
    assign ovf_o   = st_q.ovf;

    // R4: occupancy never exceeds the configured depth
    a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CW'(DEPTH))
        else $error("fifo count above depth");

    // R4: push at full together with pop keeps the FIFO full, no loss
    a_r4_full_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CW'(DEPTH) && push_i && pop_i && !flush_i)
            |=> (st_q.cnt == CW'(DEPTH)) && (ovf_o == $past(ovf_o)))
        else $error("push on dequeue at full was lost");

    // R5: overflow flag is sticky
    a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> ovf_o)
        else $error("overflow flag cleared");

endmodule

// File: rtl/veto_frame_ser.sv
module veto_frame_ser #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         flush_i,
    input  logic         en_i,
    input  logic         avail_i,
    input  logic [W-1:0] data_i,
    output logic         pop_o,
    output logic         line_o
);

    localparam int CNTW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]    shift;
        logic [CNTW-1:0] cnt;
        logic            line;
    } ser_state_t;

    ser_state_t st_d, st_q;

    assign pop_o = en_i && !flush_i && (st_q.cnt == '0) && avail_i;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else if (st_q.cnt != '0) begin
            st_d.line  = st_q.shift[W-1];
            st_d.shift = st_q.shift << 1;
            st_d.cnt   = st_q.cnt - 1'b1;
        end else if (pop_o) begin
            st_d.line  = 1'b1;
            st_d.shift = data_i;
            st_d.cnt   = CNTW'(W);
        end else begin
            st_d.line  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;

    // R2: a dequeue is followed by the start bit and a full bit count
    a_r2_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_o |=> line_o && (st_q.cnt == CNTW'(W)))
        else $error("start bit missing after dequeue");

    // R2: with nothing in flight and nothing dequeued the line stays low
    a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == '0 && !pop_o) |=> !line_o)
        else $error("line high while idle");

endmodule

// File: rtl/veto_level_gen.sv
module veto_level_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic flush_i,
    input  logic en_i,
    input  logic tick_i,
    input  logic req_i,
    output logic lvl_o
);

    typedef struct packed {
        logic pend;
        logic lvl;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else if (en_i) begin
            if (tick_i) begin
                st_d.lvl  = st_q.pend | req_i;
                st_d.pend = 1'b0;
            end else if (req_i) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    // R6: level holds between bunch ticks
    a_r6_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flush_i && !tick_i) |=> $stable(lvl_o))
        else $error("level changed off tick");

    // R6: request in the tick cycle itself vetoes that period
    a_r6_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !flush_i && tick_i && req_i) |=> lvl_o)
        else $error("same-cycle request lost");

endmodule

// File: rtl/veto_line_encoder.sv
module veto_line_encoder
    import veto_enc_pkg::*;
#(
    parameter int BUNCH_W    = 12,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               mode_sel_i,
    input  logic               train_active_i,
    input  logic               bunch_tick_i,
    input  logic               veto_req_i,
    input  logic [BUNCH_W-1:0] veto_bunch_i,
    output logic               veto_o,
    output logic               overflow_o
);

    typedef struct packed {
        veto_mode_e mode;
    } top_state_t;

    top_state_t   st_d, st_q;
    logic         mode_chg;
    logic         ser_en, lvl_en;
    logic         fifo_push, fifo_pop, fifo_avail;
    logic [BUNCH_W-1:0] fifo_head;
    logic         ser_line, lvl_line;

    always_comb begin
        st_d = st_q;
        if (!train_active_i) begin
            st_d.mode = veto_mode_e'(mode_sel_i);
        end
        mode_chg  = (st_d.mode != st_q.mode);
        ser_en    = (st_q.mode == MODE_SERIAL) && !mode_chg;
        lvl_en    = (st_q.mode == MODE_LEVEL) && !mode_chg;
        fifo_push = veto_req_i && ser_en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_SERIAL};
        end else begin
            st_q <= st_d;
        end
    end

    veto_req_fifo #(
        .W     (BUNCH_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (mode_chg),
        .push_i  (fifo_push),
        .data_i  (veto_bunch_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .avail_o (fifo_avail),
        .ovf_o   (overflow_o)
    );

    veto_frame_ser #(
        .W (BUNCH_W)
    ) u_ser (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (mode_chg),
        .en_i    (ser_en),
        .avail_i (fifo_avail),
        .data_i  (fifo_head),
        .pop_o   (fifo_pop),
        .line_o  (ser_line)
    );

    veto_level_gen u_lvl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (mode_chg),
        .en_i    (lvl_en),
        .tick_i  (bunch_tick_i),
        .req_i   (veto_req_i),
        .lvl_o   (lvl_line)
    );

    assign veto_o = (st_q.mode == MODE_LEVEL) ? lvl_line : ser_line;

    // R7: active mode frozen while a train runs
    a_r7_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        train_active_i |=> (st_q.mode == $past(st_q.mode)))
        else $error("mode changed during train");

    // R8: a mode switch leaves the line low
    a_r8_switch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg |=> !veto_o)
        else $error("line high after mode change");

endmodule

// File: tb/veto_line_encoder_tb.sv
`timescale 1ns/1ps
module veto_line_encoder_tb;

    localparam int BW    = 12;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sel = 1'b0;
    logic          train = 1'b0;
    logic          tick = 1'b0;
    logic          req = 1'b0;
    logic [BW-1:0] bunch = '0;
    logic          veto;
    logic          ovf;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    wd       = 0;
    int    tick_cnt = 0;
    string phase    = "R1";

    // reference model state
    int m_mode = 0, m_cnt = 0, m_ser = 0, m_shift = 0, m_lvl = 0, m_pend = 0, m_ovf = 0;
    int m_q[$];

    always #2 clk = ~clk;

    veto_line_encoder #(.BUNCH_W(BW), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .mode_sel_i     (mode_sel),
        .train_active_i (train),
        .bunch_tick_i   (tick),
        .veto_req_i     (req),
        .veto_bunch_i   (bunch),
        .veto_o         (veto),
        .overflow_o     (ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // bunch-period tick: one pulse every 22 fast clocks
    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == 21) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == 20);
    end

    // behavioural reference
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_ser = 0; m_shift = 0;
            m_lvl = 0; m_pend = 0; m_ovf = 0; m_q.delete();
        end else begin
            int nm;
            nm = train ? m_mode : int'(mode_sel);
            if (nm != m_mode) begin
                m_mode = nm; m_q.delete(); m_cnt = 0; m_ser = 0;
                m_shift = 0; m_lvl = 0; m_pend = 0;
            end else if (m_mode == 0) begin
                if (m_cnt > 0) begin
                    m_ser   = (m_shift >> (BW - 1)) & 1;
                    m_shift = (m_shift << 1) & ((1 << BW) - 1);
                    m_cnt--;
                end else if (m_q.size() > 0) begin
                    m_ser   = 1;
                    m_shift = m_q.pop_front();
                    m_cnt   = BW;
                end else begin
                    m_ser = 0;
                end
                if (req) begin
                    if (m_q.size() < DEPTH) m_q.push_back(int'(bunch));
                    else m_ovf = 1;
                end
            end else begin
                if (tick) begin
                    m_lvl  = (m_pend != 0 || req) ? 1 : 0;
                    m_pend = 0;
                end else if (req) begin
                    m_pend = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " line"}, int'(veto), (m_mode != 0) ? m_lvl : m_ser);
            check("R5 flag", int'(ovf), m_ovf);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check("R1 veto", int'(veto), 0);
        check("R1 ovf", int'(ovf), 0);

        // R2: single frame, exact bit timing
        phase = "R2";
        train = 1'b1;
        req = 1'b1; bunch = 12'hA5C;
        step();
        req = 1'b0;
        step();
        check("R2 start", int'(veto), 1);
        for (int i = BW - 1; i >= 0; i--) begin
            step();
            check("R2 bit", int'(veto), (12'hA5C >> i) & 1);
        end
        step();
        check("R2 idle", int'(veto), 0);

        // R3: burst of three, back to back
        phase = "R3";
        for (int i = 0; i < 3; i++) begin
            req = 1'b1; bunch = BW'(12'h101 + i * 12'h222);
            step();
        end
        req = 1'b0;
        repeat (50) step();

        // R4: push at full on the dequeue cycle
        phase = "R4";
        for (int i = 0; i < 5; i++) begin
            req = 1'b1; bunch = BW'(12'h300 + i);
            step();
        end
        req = 1'b0;
        repeat (9) step();
        req = 1'b1; bunch = 12'hFED;
        step();
        req = 1'b0;
        check("R4 no overflow", int'(ovf), 0);
        repeat (90) step();

        // R5: six back-to-back requests overflow
        phase = "R5";
        for (int i = 0; i < 6; i++) begin
            req = 1'b1; bunch = BW'(12'h050 + i);
            step();
        end
        req = 1'b0;
        check("R5 overflow set", int'(ovf), 1);
        repeat (80) step();
        check("R5 overflow held", int'(ovf), 1);

        // R7: mode select ignored during train
        phase = "R7";
        mode_sel = 1'b1;
        req = 1'b1; bunch = 12'h8F1;
        step();
        req = 1'b0;
        step();
        check("R7 serial start", int'(veto), 1);
        repeat (4) step();

        // R8: switch mid-frame (train ends, level requested)
        phase = "R8";
        train = 1'b0;
        step();
        check("R8 line low", int'(veto), 0);
        train = 1'b1;
        repeat (15) step();
        check("R8 no leftover", int'(veto), 0);

        // R6: level mode, request in the tick cycle
        phase = "R6";
        do step(); while (!tick);
        req = 1'b1;
        step();
        req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            check("R6 hold high", int'(veto), 1);
            step();
        end
        do step(); while (!tick);
        step();
        check("R6 back low", int'(veto), 0);
        // mid-period requests
        for (int i = 0; i < 120; i++) begin
            req = ((i % 31) == 5);
            step();
        end
        req = 1'b0;
        repeat (30) step();

        // R8: back to serial, flag still sticky
        phase = "R8";
        train = 1'b0; mode_sel = 1'b0;
        step();
        train = 1'b1;
        check("R8 ovf kept", int'(ovf), 1);
        req = 1'b1; bunch = 12'h3C3;
        step();
        req = 1'b0;
        repeat (20) step();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule